// File: doc/BRIEF.md
# Configurable Interrupt Controller with Normal and Fast Request Outputs

The block collects a vector of interrupt request lines, by default 32 of them, and turns them into two processor request outputs. Each line is first brought into the local clock domain. Software then chooses for each line whether it is sensed as a level or latched as an edge, and which sense is the active one. Edge events are held in a latch until software clears them by writing ones. A level line simply shows its current state after the polarity correction.

A per-source enable mask gates the pending sources into a status view. A per-source route bit sends each enabled, pending source either to the normal request output or to the fast request output. Software reaches every setting through a small synchronous register port. The port has a word address, write data as wide as the source vector, and read data that returns one cycle after the request. Priority encoding and vectoring are left to the software that reads the status register.

Top module: `irq_router`

## Requirements
- R1: After reset the enable, polarity, trigger-type and route registers read zero and both request outputs are low; with all inputs low, the raw register then reads all ones, because every source is level-sensed and active low.
- R2: Registers sit at word addresses 0 (enable), 1 (raw), 2 (status), 3 (polarity), 4 (trigger type) and 5 (route); read data appears on the clock edge that takes the read request and is zero in any other cycle. Writes to address 2 and accesses to addresses 6 and 7 have no effect and read zero.
- R3: For a source whose trigger-type bit is 0, the raw bit equals the input when its polarity bit is 1 and the inverted input when it is 0. Writing ones to the raw register does not change a level source.
- R4: For a source whose trigger-type bit is 1, a rising input edge (polarity 1) or a falling input edge (polarity 0) sets the raw bit, which stays set after the input returns to idle. The opposite transition sets nothing.
- R5: Writing a 1 to a raw-register bit clears that source's latched edge; writing a 0 leaves it unchanged.
- R6: The status register reads raw AND enable, bit by bit.
- R7: The normal output is high when any status bit has route bit 0, and the fast output is high when any status bit has route bit 1; with no enabled pending source both are low.
- R8: For a level source that is enabled and routed normal, a change of its input reaches the normal output on the third rising clock edge after the change (two synchroniser stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Interrupt request lines, asynchronous to clk_i |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | N_SRC | Write data, one bit per source |
| rdata_o | output | N_SRC | Read data, valid the cycle after a read request |
| nrm_irq_o | output | 1 | Normal interrupt request |
| fast_irq_o | output | 1 | Fast interrupt request |

## Verification
A stuck or wrongly cleared edge latch shows up in the raw register on the first read after the disturbing event. A wrong route or mask bit shows on the request outputs one clock after the status changes, so the bench sweeps every source singly through both routes. Synchroniser depth errors shift the output by whole cycles and are caught by sampling the normal output on each of the three edges after a level change. Polarity and trigger-type errors surface as a raw read that is inverted or missing a bit when the bench walks a single active bit across all sources in each mode.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_EN   = 3'd0,
    REG_RAW  = 3'd1,
    REG_STAT = 3'd2,
    REG_POL  = 3'd3,
    REG_TRIG = 3'd4,
    REG_FSEL = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] prev_q, edge_q, ev;

  for (genvar g = 0; g < W; g++) begin : g_src
    assign ev[g]    = pol_i[g] ? (sync_i[g] & ~prev_q[g]) : (~sync_i[g] & prev_q[g]);
    assign raw_o[g] = trig_i[g] ? edge_q[g] : ~(sync_i[g] ^ pol_i[g]);
  end

  // new event beats a same-cycle ack; latch cleared while source is level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= sync_i;
      edge_q <= trig_i & ((edge_q & ~ack_i) | ev);
    end
  end

  // R5
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_q & $past(ack_i & ~ev)) == '0));

  // R4
  edge_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(ev)) == '0));

  // R3
  lvl_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(sync_i) && $stable(pol_i) && $stable(trig_i))
      |-> (((raw_o ^ $past(raw_o)) & ~trig_i) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      trig_o,
  output logic [W-1:0]      fsel_o,
  output logic [W-1:0]      stat_o,
  output logic [W-1:0]      ack_o
);
  logic [W-1:0] en_q, pol_q, trig_q, fsel_q, rdata_q;
  logic wr, rd;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign stat_o = raw_i & en_q;
  assign ack_o  = (wr && addr_i == REG_RAW) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      fsel_q <= '0;
    end else if (wr) begin
      case (addr_i)
        REG_EN:   en_q   <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_TRIG: trig_q <= wdata_i;
        REG_FSEL: fsel_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      case (addr_i)
        REG_EN:   rdata_q <= en_q;
        REG_RAW:  rdata_q <= raw_i;
        REG_STAT: rdata_q <= stat_o;
        REG_POL:  rdata_q <= pol_q;
        REG_TRIG: rdata_q <= trig_q;
        REG_FSEL: rdata_q <= fsel_q;
        default:  rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
  assign fsel_o  = fsel_q;

  // R2
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != '0) |-> $past(rd));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              nrm_irq_o,
  output logic              fast_irq_o
);
  logic [N_SRC-1:0] sync, raw, en, pol, trig, fsel, stat, ack;
  logic nrm_q, fast_q;

  irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(irq_i), .q_o(sync)
  );

  irq_detect #(.W(N_SRC)) u_detect (
    .clk_i, .rst_ni, .sync_i(sync), .pol_i(pol), .trig_i(trig),
    .ack_i(ack), .raw_o(raw)
  );

  irq_regs #(.W(N_SRC)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .raw_i(raw),
    .rdata_o, .en_o(en), .pol_o(pol), .trig_o(trig), .fsel_o(fsel),
    .stat_o(stat), .ack_o(ack)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nrm_q  <= 1'b0;
      fast_q <= 1'b0;
    end else begin
      nrm_q  <= |(stat & ~fsel);
      fast_q <= |(stat & fsel);
    end
  end

  assign nrm_irq_o  = nrm_q;
  assign fast_irq_o = fast_q;

  // R7
  nrm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrm_irq_o |-> $past(|(en & ~fsel)));

  // R7
  fast_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_irq_o |-> $past(|(en & fsel)));
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int N = 32;
  localparam logic [2:0] A_EN = 3'd0, A_RAW = 3'd1, A_STAT = 3'd2,
                         A_POL = 3'd3, A_TRIG = 3'd4, A_FSEL = 3'd5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] irq_in = '0, wdata = '0, rdata;
  logic req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic nrm, fst;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_in), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .nrm_irq_o(nrm), .fast_irq_o(fst)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_in(input logic [N-1:0] v);
    @(negedge clk); irq_in = v;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [N-1:0] outs();
    return {{(N-2){1'b0}}, nrm, fst};
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [N-1:0] v, v0, latch, idle, pol;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    rd(A_EN, v);   chk("R1 en", v, '0);
    rd(A_POL, v);  chk("R1 pol", v, '0);
    rd(A_TRIG, v); chk("R1 trig", v, '0);
    rd(A_FSEL, v); chk("R1 fsel", v, '0);
    chk("R1 outs", outs(), '0);
    rd(A_RAW, v);  chk("R1 raw all active-low", v, '1);
    rd(A_STAT, v); chk("R1 stat", v, '0);

    // R2 register map
    for (int a = 0; a < 6; a++) begin
      if (a == 1 || a == 2) continue;
      wr(3'(a), 32'hA5C3_0F00 ^ 32'(a));
      rd(3'(a), v);
      chk("R2 readback", v, 32'hA5C3_0F00 ^ 32'(a));
    end
    rd(A_STAT, v0);
    wr(A_STAT, '1);
    rd(A_STAT, v); chk("R2 stat read-only", v, v0);
    wr(3'd6, '1); rd(3'd6, v); chk("R2 addr6", v, '0);
    wr(3'd7, '1); rd(3'd7, v); chk("R2 addr7", v, '0);
    @(negedge clk); chk("R2 rdata idle", rdata, '0);
    wr(A_EN, '0); wr(A_POL, '0); wr(A_TRIG, '0); wr(A_FSEL, '0);

    // R3 level, both polarities
    wr(A_POL, '1);
    for (int i = 0; i < N; i++) begin
      set_in(32'h1 << i);
      rd(A_RAW, v); chk("R3 level high", v, 32'h1 << i);
    end
    wr(A_POL, '0);
    for (int i = 0; i < 8; i++) begin
      v0 = 32'h9E37_79B9 * (i + 1);
      set_in(v0);
      rd(A_RAW, v); chk("R3 level low", v, ~v0);
    end
    wr(A_RAW, '1);
    rd(A_RAW, v); chk("R3 ack ignored on level", v, ~v0);

    // R4 edge latching, low half rising, high half falling
    pol = 32'h0000_FFFF;
    idle = ~pol;
    set_in(idle);
    wr(A_POL, pol);
    wr(A_TRIG, '1);
    repeat (3) @(negedge clk);
    rd(A_RAW, v); chk("R4 no spurious edge", v, '0);
    latch = '0;
    for (int i = 0; i < N; i++) begin
      set_in(idle ^ (32'h1 << i));
      set_in(idle);
      latch |= 32'h1 << i;
      rd(A_RAW, v); chk("R4 edge latched", v, latch);
    end

    // R5 write-one clear
    wr(A_RAW, 32'h0F0F_0F0F);
    latch &= ~32'h0F0F_0F0F;
    rd(A_RAW, v); chk("R5 w1c", v, latch);
    wr(A_RAW, '0);
    rd(A_RAW, v); chk("R5 zero write", v, latch);

    // R6 status masking
    for (int i = 0; i < 6; i++) begin
      v0 = (i == 0) ? '0 : (i == 1) ? '1 : 32'h1234_5678 * i;
      wr(A_EN, v0);
      rd(A_STAT, v); chk("R6 status", v, latch & v0);
    end

    // R7 routing of each source
    wr(A_EN, '0);
    set_in(~idle);
    set_in(idle);
    rd(A_RAW, v); chk("R4 all latched", v, '1);
    repeat (2) @(negedge clk);
    chk("R7 masked off", outs(), '0);
    for (int k = 0; k < N; k++) begin
      for (int f = 0; f < 2; f++) begin
        wr(A_EN, 32'h1 << k);
        wr(A_FSEL, (f == 1) ? (32'h1 << k) : ~(32'h1 << k));
        repeat (2) @(negedge clk);
        chk("R7 route", outs(), (f == 1) ? 32'd1 : 32'd2);
      end
    end
    wr(A_EN, '0);
    repeat (2) @(negedge clk);
    chk("R7 all masked", outs(), '0);

    // R8 level latency
    wr(A_TRIG, '0); wr(A_POL, '1); wr(A_FSEL, '0);
    set_in('0);
    wr(A_EN, 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 idle", outs(), '0);
    irq_in = 32'h1;
    @(negedge clk); chk("R8 edge1", outs(), '0);
    @(negedge clk); chk("R8 edge2", outs(), '0);
    @(negedge clk); chk("R8 edge3", outs(), 32'd2);

    finish_run();
  end
endmodule